// File: doc/BRIEF.md
# UART Receiver with Break-Field Trigger

This block receives 8-bit asynchronous serial characters. It oversamples the line on an external sample tick and reports framing, parity and overrun errors. It also has a break-field mode that software arms, as used at the start of LIN-style frame headers. Writing the arm bit puts the receiver into break mode, and a status bit shows that break reception is in progress. Measurement starts on the next falling edge of the line. The break is accepted when the line rises again after staying low for at least eleven bit times.

A mode bit selects how completion is reported. It is either the ordinary receive interrupt pulse, or a sticky break flag together with a separate status interrupt pulse. If the arm bit is written while a character is being received, that character is dropped without any trace. The low-level counter keeps running across the abort, so the character's start bit counts toward the break length. Software reaches the block through a small strobe-based register port with four byte-wide locations:

- CTRL (address 0): bit0 enable, bit1 receive enable, bit2 break mode, bit3 parity enable, bit4 odd parity.
- CMD (address 1): write-1 bits. Bit0 arms break reception, bit1 clears the break flag, bit2 clears the error flags.
- STAT (address 2): bit0 break active, bit1 break flag, bit2 framing error, bit3 parity error, bit4 overrun, bit5 data valid.
- DATA (address 3): the last received byte.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, CTRL, STAT and DATA read 0x00, and both interrupt outputs are low.
- R2: With CTRL bit0 and bit1 set, a frame is stored in DATA and sets STAT bit5. A frame is a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit, 16 ticks per bit. rx_irq_o pulses for exactly one cycle at the middle of the stop bit.
- R3: With CTRL bit3 set, a parity bit follows the data, even parity when CTRL bit4 is 0 and odd when it is 1. A mismatch sets STAT bit3.
- R4: A stop bit sampled low sets STAT bit2. The byte is still stored and rx_irq_o still pulses.
- R5: A byte completing while STAT bit5 is still set stores the new byte and sets STAT bit4. A read of DATA with rd_i high clears STAT bit5.
- R6: CMD always reads 0x00, and writing 0x00 to CMD changes no STAT bit.
- R7: Writing 1 to CMD bit0 sets STAT bit0 only when CTRL bit0 and bit1 are both 1. Otherwise the write is ignored.
- R8: Once armed, a low period that begins with a falling edge and lasts at least 11 bit times completes the break on its rising edge. A shorter low period leaves STAT bit0 set and produces no interrupt.
- R9: With CTRL bit2 at 0, break completion clears STAT bit0, pulses rx_irq_o once and leaves STAT bit1 at 0.
- R10: With CTRL bit2 at 1, break completion sets STAT bit1 and pulses st_irq_o for one cycle. STAT bit1 stays set until a write of 1 to CMD bit1.
- R11: Arming during a character in progress drops it: DATA, STAT bit5 and the error flags stay unchanged and no interrupt is raised for it. The low time already counted since its start edge counts toward the break.
- R12: A second write of CMD bit0 while break reception is active is ignored and does not restart the measurement.
- R13: Writing 1 to CMD bit2 clears STAT bits 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rxd_i | input | 1 | Serial receive line, idle high |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect on DATA) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rx_irq_o | output | 1 | Receive-complete interrupt pulse |
| st_irq_o | output | 1 | Break status interrupt pulse |

## Verification
The line passes through two synchronizer flops and an edge detector. The core samples at the middle of each bit, and the interrupt is registered once more. So rx_irq_o for a character is due about half a bit time before the frame's nominal end, plus a few cycles of synchronizer and tick-phase delay. The bench records the cycle of every interrupt pulse and requires it to fall inside a window derived from the frame length. A break completion is due between two and eight cycles after the line rises. Register values are read back only after the expected interrupt window has closed, and pulses are sampled on the falling clock edge so each one is counted once and any pulse wider than one cycle is caught.

// File: rtl/uart_bf_pkg.sv
package uart_bf_pkg;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {BK_OFF, BK_WAIT, BK_MEAS} bk_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       par_odd;
    logic       par_en;
    logic       brk_mode;
    logic       rx_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/uart_bf_sync.sv
module uart_bf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rise_o = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/uart_bf_rx_core.sv
module uart_bf_rx_core
  import uart_bf_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          fall_i,
  input  logic          hold_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          fe_o,
  output logic          pe_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q;
  logic [CW-1:0] sc_q;
  logic [BW-1:0] bi_q;
  logic [DW-1:0] sh_q;
  logic          pb_q;
  logic          smp;

  assign smp    = tick_i && (sc_q == LAST);
  assign busy_o = (state_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sc_q    <= '0;
      bi_q    <= '0;
      sh_q    <= '0;
      pb_q    <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (hold_i) begin
        state_q <= RX_IDLE;
      end else begin
        if (tick_i && state_q != RX_IDLE) sc_q <= (smp || (state_q == RX_START && sc_q == MID)) ? '0 : sc_q + 1'b1;
        unique case (state_q)
          RX_IDLE: if (fall_i) begin
            state_q <= RX_START;
            sc_q    <= '0;
          end
          RX_START: if (tick_i && sc_q == MID) begin
            if (!rx_i) begin
              state_q <= RX_DATA;
              bi_q    <= '0;
            end else begin
              state_q <= RX_IDLE;
            end
          end
          RX_DATA: if (smp) begin
            sh_q <= {rx_i, sh_q[DW-1:1]};
            if (bi_q == BW'(DW-1)) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else                   bi_q    <= bi_q + 1'b1;
          end
          RX_PAR: if (smp) begin
            pb_q    <= rx_i;
            state_q <= RX_STOP;
          end
          RX_STOP: if (smp) begin
            done_o  <= 1'b1;
            data_o  <= sh_q;
            fe_o    <= ~rx_i;
            pe_o    <= par_en_i & ((^sh_q ^ pb_q) != par_odd_i);
            state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!done_o && !busy_o));

  p_done_from_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == RX_STOP));
endmodule

// File: rtl/uart_bf_brk.sv
module uart_bf_brk
  import uart_bf_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic arm_i,
  input  logic allow_i,
  input  logic core_busy_i,
  output logic active_o,
  output logic done_o
);
  localparam int THR = OSR * BRK_BITS;
  localparam int KW  = $clog2(THR + 1);
  localparam logic [KW-1:0] THR_V = KW'(THR);

  bk_state_e     st_q;
  logic [KW-1:0] cnt_q;

  // low-time counter runs regardless of arming; survives an abort
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (rx_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != THR_V) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BK_OFF;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!allow_i) begin
        st_q <= BK_OFF;
      end else begin
        unique case (st_q)
          BK_OFF:  if (arm_i) st_q <= core_busy_i ? BK_MEAS : BK_WAIT;
          BK_WAIT: if (fall_i) st_q <= BK_MEAS;
          BK_MEAS: if (rise_i) begin
            if (cnt_q >= THR_V) begin
              st_q   <= BK_OFF;
              done_o <= 1'b1;
            end else begin
              st_q <= BK_WAIT;
            end
          end
          default: st_q <= BK_OFF;
        endcase
      end
    end
  end

  assign active_o = (st_q != BK_OFF);

  p_arm_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_OFF && arm_i && !allow_i) |=> (st_q == BK_OFF));

  p_done_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(st_q == BK_MEAS) && $past(rise_i)));

  p_rearm_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_MEAS && arm_i && allow_i && !rise_i) |=> (st_q == BK_MEAS));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_bf_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11,
  parameter int SYNC     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rx_irq_o,
  output logic       st_irq_o
);
  localparam int DW = 8;

  ctrl_t         ctrl_q;
  logic [DW-1:0] data_q;
  logic          valid_q, fe_q, pe_q, ovr_q, brk_flag_q;

  logic          rx_lvl, rx_fall, rx_rise;
  logic          core_busy, core_done, core_fe, core_pe;
  logic [DW-1:0] core_data;
  logic          brk_active, brk_done;
  logic          allow, wr_cmd, arm, rd_data;

  assign allow   = ctrl_q.en & ctrl_q.rx_en;
  assign wr_cmd  = wr_i && (addr_i == A_CMD);
  assign arm     = wr_cmd && wdata_i[0];
  assign rd_data = rd_i && (addr_i == A_DATA);

  uart_bf_sync #(.STAGES(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .lvl_o (rx_lvl),
    .fall_o(rx_fall),
    .rise_o(rx_rise)
  );

  uart_bf_rx_core #(.OSR(OSR), .DW(DW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rx_i     (rx_lvl),
    .fall_i   (rx_fall),
    .hold_i   (brk_active | ~allow),
    .par_en_i (ctrl_q.par_en),
    .par_odd_i(ctrl_q.par_odd),
    .busy_o   (core_busy),
    .done_o   (core_done),
    .data_o   (core_data),
    .fe_o     (core_fe),
    .pe_o     (core_pe)
  );

  uart_bf_brk #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_i       (rx_lvl),
    .fall_i     (rx_fall),
    .rise_i     (rx_rise),
    .arm_i      (arm),
    .allow_i    (allow),
    .core_busy_i(core_busy),
    .active_o   (brk_active),
    .done_o     (brk_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
      fe_q       <= 1'b0;
      pe_q       <= 1'b0;
      ovr_q      <= 1'b0;
      brk_flag_q <= 1'b0;
      rx_irq_o   <= 1'b0;
      st_irq_o   <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      rx_irq_o <= core_done | (brk_done & ~ctrl_q.brk_mode);
      st_irq_o <= brk_done & ctrl_q.brk_mode;

      if (brk_done && ctrl_q.brk_mode)  brk_flag_q <= 1'b1;
      else if (wr_cmd && wdata_i[1])    brk_flag_q <= 1'b0;

      if (wr_cmd && wdata_i[2]) begin
        fe_q  <= 1'b0;
        pe_q  <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (rd_data) valid_q <= 1'b0;
      if (core_done) begin
        data_q  <= core_data;
        valid_q <= 1'b1;
        if (core_fe) fe_q <= 1'b1;
        if (core_pe) pe_q <= 1'b1;
        if (valid_q && !rd_data) ovr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {2'b00, valid_q, ovr_q, pe_q, fe_q, brk_flag_q, brk_active};
      A_DATA:  rdata_o = data_q;
      default: rdata_o = 8'h00;
    endcase
  end

  p_rx_irq_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  p_st_irq_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_irq_o |-> brk_flag_q);

  p_abort_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_active && $past(brk_active)) |-> !core_done);

  p_flag_needs_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_q) |-> $past(ctrl_q.brk_mode));
endmodule

// File: tb/uart_brk_rx_test.sv
`timescale 1ns/1ps
module uart_brk_rx_test;
  localparam int OSR = 16;
  localparam int BIT = OSR * 2; // tick every other cycle

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rx_irq, st_irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rx_cnt = 0, st_cnt = 0, last_rx = 0, last_st = 0, wide = 0;
  logic prev_rx = 1'b0, prev_st = 1'b0, done_flag = 1'b0;

  uart_brk_rx #(.OSR(OSR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_irq_o(rx_irq), .st_irq_o(st_irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(negedge clk) begin
    if (rx_irq) begin rx_cnt++; last_rx = cyc; end
    if (st_irq) begin st_cnt++; last_st = cyc; end
    if ((rx_irq && prev_rx) || (st_irq && prev_st)) wide++;
    prev_rx = rx_irq;
    prev_st = st_irq;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic strobe, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = strobe;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic par_bit(input logic [7:0] b, input logic odd);
    return ^b ^ odd;
  endfunction

  // drives one frame; returns cycle of start edge
  task automatic send(input logic [7:0] b, input logic pen, input logic odd,
                      input logic bad_par, input logic bad_stop, output int t0);
    @(negedge clk);
    t0 = cyc;
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (pen) begin
      rxd = par_bit(b, odd) ^ bad_par;
      repeat (BIT) @(negedge clk);
    end
    rxd = ~bad_stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic low_for(input int bits);
    rxd = 1'b0;
    repeat (bits * BIT) @(negedge clk);
  endtask

  task automatic release_line(output int tr);
    tr = cyc;
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic frame_check(input string req, input logic [7:0] b, input logic pen,
                             input logic odd, input logic bad_par, input logic bad_stop,
                             input logic [7:0] exp_stat);
    int t0, nb, rc0;
    logic [7:0] v;
    rc0 = rx_cnt;
    send(b, pen, odd, bad_par, bad_stop, t0);
    nb = pen ? 11 : 10;
    check({req, " irq count"}, rx_cnt, rc0 + 1);
    check_win({req, " irq timing"}, last_rx - t0, nb * BIT - BIT / 2, nb * BIT - BIT / 2 + 12);
    rreg(2'd3, 1'b0, v);
    check({req, " data"}, v, b);
    rreg(2'd2, 1'b0, v);
    check({req, " status"}, v, exp_stat);
  endtask

  initial begin
    logic [7:0] v;
    int t0, tr, rc0, sc0;
    logic [7:0] b;
    logic pen, odd, bp, bs;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rreg(2'd0, 1'b0, v); check("R1 ctrl", v, 8'h00);
    rreg(2'd2, 1'b0, v); check("R1 stat", v, 8'h00);
    rreg(2'd3, 1'b0, v); check("R1 data", v, 8'h00);
    check("R1 irq", {rx_irq, st_irq}, 0);

    wreg(2'd0, 8'h03);
    // R2 plain frame
    frame_check("R2 8N1", 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
    rreg(2'd3, 1'b1, v);
    rreg(2'd2, 1'b0, v); check("R5 read clears valid", v, 8'h00);

    // R3 parity
    wreg(2'd0, 8'h0B);
    frame_check("R3 even ok", 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 8'h20);
    rreg(2'd3, 1'b1, v);
    frame_check("R3 even bad", 8'h3D, 1'b1, 1'b0, 1'b1, 1'b0, 8'h28);
    rreg(2'd3, 1'b1, v);
    wreg(2'd1, 8'h04);
    wreg(2'd0, 8'h1B);
    frame_check("R3 odd ok", 8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20);
    rreg(2'd3, 1'b1, v);

    // R4 framing error
    wreg(2'd0, 8'h03);
    frame_check("R4 stop low", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 8'h24);
    rreg(2'd3, 1'b1, v);
    // R13 clear errors
    wreg(2'd1, 8'h04);
    rreg(2'd2, 1'b0, v); check("R13 clear", v, 8'h00);

    // R5 overrun
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, t0);
    frame_check("R5 overrun", 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 8'h30);
    rreg(2'd3, 1'b1, v);
    // R6 write 0 to CMD has no effect, CMD reads 0
    wreg(2'd1, 8'h00);
    rreg(2'd2, 1'b0, v); check("R6 zero write", v, 8'h10);
    rreg(2'd1, 1'b0, v); check("R6 cmd reads 0", v, 8'h00);
    wreg(2'd1, 8'h04);
    rreg(2'd2, 1'b0, v); check("R13 ovr cleared", v, 8'h00);

    // random frames
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) begin
      b   = 8'($urandom());
      pen = 1'($urandom());
      odd = 1'($urandom());
      bp  = pen & (($urandom() % 4) == 0);
      bs  = (($urandom() % 5) == 0);
      wreg(2'd0, {3'b000, odd, pen, 3'b011});
      frame_check("R2 random", b, pen, odd, bp, bs, {2'b00, 1'b1, 1'b0, bp, bs, 2'b00});
      rreg(2'd3, 1'b1, v);
      wreg(2'd1, 8'h04);
    end

    // R7 arm gating
    wreg(2'd0, 8'h01);
    wreg(2'd1, 8'h01);
    rreg(2'd2, 1'b0, v); check("R7 arm ignored rx off", v, 8'h00);
    wreg(2'd0, 8'h03);
    wreg(2'd1, 8'h01);
    rreg(2'd2, 1'b0, v); check("R7 arm accepted", v, 8'h01);

    // R9 mode 0 completion
    rc0 = rx_cnt; sc0 = st_cnt;
    low_for(12);
    release_line(tr);
    check("R9 rx irq", rx_cnt, rc0 + 1);
    check_win("R9 timing", last_rx - tr, 2, 8);
    check("R9 no st irq", st_cnt, sc0);
    rreg(2'd2, 1'b0, v); check("R9 stat", v, 8'h00);

    // R8 short low, then full break, mode 1
    wreg(2'd0, 8'h07);
    wreg(2'd1, 8'h01);
    rc0 = rx_cnt; sc0 = st_cnt;
    low_for(10);
    release_line(tr);
    check("R8 short no irq", rx_cnt + st_cnt, rc0 + sc0);
    rreg(2'd2, 1'b0, v); check("R8 still armed", v, 8'h01);
    low_for(12);
    release_line(tr);
    check("R10 st irq", st_cnt, sc0 + 1);
    check_win("R10 timing", last_st - tr, 2, 8);
    check("R10 no rx irq", rx_cnt, rc0);
    repeat (50) @(negedge clk);
    rreg(2'd2, 1'b0, v); check("R10 flag sticky", v, 8'h02);
    wreg(2'd1, 8'h02);
    rreg(2'd2, 1'b0, v); check("R10 flag cleared", v, 8'h00);

    // R12 re-arm during measurement ignored
    wreg(2'd1, 8'h01);
    sc0 = st_cnt;
    rxd = 1'b0;
    repeat (4 * BIT) @(negedge clk);
    wreg(2'd1, 8'h01);
    repeat (8 * BIT - 2) @(negedge clk);
    release_line(tr);
    check("R12 completes", st_cnt, sc0 + 1);
    wreg(2'd1, 8'h02);

    // R11 abort mid-character; counter spans the abort
    rc0 = rx_cnt; sc0 = st_cnt;
    rxd = 1'b0;
    repeat (3 * BIT) @(negedge clk);
    wreg(2'd1, 8'h01);
    repeat (9 * BIT - 2) @(negedge clk);
    release_line(tr);
    repeat (12 * BIT) @(negedge clk);
    check("R11 no rx irq", rx_cnt, rc0);
    check("R11 break done", st_cnt, sc0 + 1);
    rreg(2'd2, 1'b0, v); check("R11 stat", v, 8'h02);
    rreg(2'd3, 1'b0, v); check("R11 data kept", v, b);

    check("R2 R10 pulse width", wide, 0);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule